// File: doc/BRIEF.md
# SPI Flash Continuation Bulk Loader

This block takes over a serial flash that an earlier boot stage has left in the middle of a read. On entry the chip select and the serial clock are both driven low, and the flash is already presenting the most significant bit of the next byte on its data output. No command or address is ever sent. The block clocks in a programmed number of further bytes and writes each one into a byte-wide memory write port at successive addresses. It then pulses a launch signal so that the loaded image can be started.

The serial clock runs at half the system clock rate, with one clock-pin transition per system cycle. The transfer is cut into bounded chunks of at most `CHUNK_MAX` bytes. Each chunk burns exactly sixteen transitions per byte. Between chunks the clock rests low while chip select stays low, so the flash keeps its read position. Received bits pass through a `SAMPLE_LAT`-stage input pipeline, and the sample strobe is delayed by the same amount. This follows the latency of the pin input path.

A request with a zero byte count is already satisfied. It reads nothing and fires the launch pulse at once.

Top module: `spi_cont_loader`

## Requirements
- R1: While and directly after reset, `spi_sck`, `mem_we`, `busy`, `done` and `launch` are all low.
- R2: `spi_cs_n` is low in every cycle, including across chunk boundaries and while idle.
- R3: `spi_sck` is low whenever the block is not busy, and is never high in two consecutive cycles: it toggles once per system cycle while streaming.
- R4: A transfer of N bytes is split into runs of clock pulses, separated by at least two low cycles. Every run except the last carries 8·`CHUNK_MAX` rising edges. The last run carries 8·(remaining bytes).
- R5: Bytes are assembled most significant bit first. The first bit is the value the flash presents before the first clock edge. Each later bit is the value on `spi_miso` while `spi_sck` is high.
- R6: Byte k of a transfer is written with `mem_addr` = (`base_addr` + k) modulo 2^`ADDR_W`. There is exactly one `mem_we` cycle per byte.
- R7: When `start` is sampled in idle with `byte_count` = 0, `launch` is high in the very next cycle, with no clock pulse and no write.
- R8: `launch` is high for one cycle, exactly two cycles after the last `mem_we` cycle. `done` then goes high and holds until the next accepted `start`.
- R9: `start` is ignored unless the block is idle, including in the cycle in which `launch` is high.
- R10: The first `mem_we` of a non-empty transfer appears 17 + `SAMPLE_LAT` cycles after the clock edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled only in idle) |
| byte_count | input | CNT_W | Number of bytes still to load |
| base_addr | input | ADDR_W | Memory address of the first loaded byte |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, held low |
| spi_miso | input | 1 | Flash data output |
| mem_we | output | 1 | Memory write strobe, one cycle per byte |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | High from an accepted start through the launch cycle |
| done | output | 1 | High after launch until the next accepted start |
| launch | output | 1 | One-cycle pulse to start the loaded image |

## Verification
The two events that can coincide are a new `start` request and the launch cycle that ends the previous request. The clearest case is a zero-length request, where launch follows start directly. The bench issues a zero-count start and holds `start` high with a fresh non-zero count in exactly the cycle `launch` shows. It judges by counting launches, writes and clock edges over the following cycles, all of which must stay at one, zero and zero. A second start pulse is also placed in the middle of a multi-chunk stream, and the write sequence and chunk runs must remain those of the first request.

// File: rtl/spi_cont_loader_pkg.sv
package spi_cont_loader_pkg;

    // sixteen clock transitions per byte: two per bit, eight bits
    localparam int TOG_PER_BYTE_LOG2 = 4;
    localparam int BYTE_BITS         = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STREAM,
        ST_FINISH
    } ld_state_t;

    // one delayed sample of the data line
    typedef struct packed {
        logic valid;
        logic value;
    } bit_sample_t;

endpackage

// File: rtl/scl_sck_toggler.sv
module scl_sck_toggler #(
    parameter int TOG_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TOG_W-1:0] load_val,
    output logic             sck,
    output logic             idle
);

    logic [TOG_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            sck  <= 1'b0;
        end else if (load) begin
            left <= load_val;
        end else if (left != '0) begin
            left <= left - 1'b1;
            sck  <= ~sck;
        end
    end

    assign idle = (left == '0);

    // R3
    sck_rests_low_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> !sck);

endmodule

// File: rtl/scl_sample_pipe.sv
module scl_sample_pipe
    import spi_cont_loader_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck,
    input  logic        miso,
    output bit_sample_t smp
);

    logic [LAT-1:0] hi_q;
    logic [LAT-1:0] dat_q;

    generate
        if (LAT == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    hi_q  <= '0;
                    dat_q <= '0;
                end else begin
                    hi_q[0]  <= sck;
                    dat_q[0] <= miso;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    hi_q  <= '0;
                    dat_q <= '0;
                end else begin
                    hi_q  <= {hi_q[LAT-2:0], sck};
                    dat_q <= {dat_q[LAT-2:0], miso};
                end
            end
        end
    endgenerate

    assign smp.valid = hi_q[LAT-1];
    assign smp.value = dat_q[LAT-1];

    // R3: the clock is never high twice in a row, so neither are samples
    sample_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        smp.valid |=> !smp.valid);

endmodule

// File: rtl/scl_byte_packer.sv
module scl_byte_packer
    import spi_cont_loader_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic [ADDR_W-1:0] base,
    input  bit_sample_t       smp,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    logic [BYTE_BITS-2:0] shreg;
    logic [2:0]           bitcnt;
    logic [ADDR_W-1:0]    next_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            bitcnt    <= '0;
            next_addr <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (init) begin
                next_addr <= base;
                bitcnt    <= '0;
            end else if (smp.valid) begin
                shreg  <= {shreg[BYTE_BITS-3:0], smp.value};
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == 3'd7) begin
                    mem_we    <= 1'b1;
                    mem_wdata <= {shreg, smp.value};
                    mem_addr  <= next_addr;
                    next_addr <= next_addr + 1'b1;
                end
            end
        end
    end

    // R6: a byte needs sixteen cycles, so strobes never touch
    we_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

endmodule

// File: rtl/spi_cont_loader.sv
module spi_cont_loader
    import spi_cont_loader_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int ADDR_W     = 20,
    parameter int CHUNK_MAX  = 8191,
    parameter int SAMPLE_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              spi_sck,
    output logic              spi_cs_n,
    input  logic              spi_miso,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              launch
);

    localparam int CHUNK_W = $clog2(CHUNK_MAX + 1);
    localparam int TOG_W   = CHUNK_W + TOG_PER_BYTE_LOG2;

    ld_state_t          state;
    logic [CNT_W-1:0]   rem;
    logic [CHUNK_W-1:0] chunk_left;
    logic [CHUNK_W-1:0] chunk_sel;
    logic [31:0]        rem_ext;
    logic [TOG_W-1:0]   tog_load;
    logic               tog_idle;
    logic               accept;
    bit_sample_t        smp;

    assign accept   = (state == ST_IDLE) && start;
    assign rem_ext  = 32'(rem);
    assign chunk_sel = (rem_ext > 32'(CHUNK_MAX)) ? CHUNK_W'(CHUNK_MAX)
                                                  : CHUNK_W'(rem_ext);
    assign tog_load = {chunk_sel, {TOG_PER_BYTE_LOG2{1'b0}}};

    // chip select stays asserted so the flash read address never restarts
    assign spi_cs_n = 1'b0;
    assign busy     = (state != ST_IDLE);
    assign launch   = (state == ST_FINISH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            rem   <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        rem   <= byte_count;
                        done  <= 1'b0;
                        state <= (byte_count == '0) ? ST_FINISH : ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    rem   <= rem - CNT_W'(chunk_sel);
                    state <= ST_STREAM;
                end
                ST_STREAM: begin
                    if (tog_idle && chunk_left == '0)
                        state <= (rem == '0) ? ST_FINISH : ST_LOAD;
                end
                ST_FINISH: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            chunk_left <= '0;
        else if (state == ST_LOAD)
            chunk_left <= chunk_sel;
        else if (mem_we && chunk_left != '0)
            chunk_left <= chunk_left - 1'b1;
    end

    scl_sck_toggler #(.TOG_W(TOG_W)) u_tog (
        .clk      (clk),
        .rst      (rst),
        .load     (state == ST_LOAD),
        .load_val (tog_load),
        .sck      (spi_sck),
        .idle     (tog_idle)
    );

    scl_sample_pipe #(.LAT(SAMPLE_LAT)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .sck  (spi_sck),
        .miso (spi_miso),
        .smp  (smp)
    );

    scl_byte_packer #(.ADDR_W(ADDR_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .init      (accept),
        .base      (base_addr),
        .smp       (smp),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R3
    idle_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !spi_sck);

    // R8
    launch_single_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> !launch);

    // R8
    launch_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> done);

    // R6
    write_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R4
    chunk_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(chunk_left) <= 32'(CHUNK_MAX));

    // R8
    no_write_at_launch_chk: assert property (@(posedge clk) disable iff (rst)
        !(launch && mem_we));

endmodule

// File: tb/spi_cont_loader_tb.sv
module spi_cont_loader_tb;

    localparam int CNT_W = 12, ADDR_W = 10, CHUNK_MAX = 4, LAT = 2;

    logic              clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [CNT_W-1:0]  byte_count = '0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic              spi_sck, spi_cs_n, spi_miso, mem_we, busy, done, launch;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;

    spi_cont_loader #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CHUNK_MAX(CHUNK_MAX),
                      .SAMPLE_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
        .base_addr(base_addr), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_miso(spi_miso), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done), .launch(launch));

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // flash model: a byte stream, bit pointer advanced on each falling clock
    function automatic logic [7:0] fbyte(int j);
        return 8'((j * 53 + 17) ^ (j >> 2));
    endfunction
    function automatic logic fbit(int p);
        logic [7:0] b;
        b = fbyte(p / 8);
        return b[7 - (p % 8)];
    endfunction

    int fptr = 0;
    always_comb spi_miso = fbit(fptr);

    // reference model state
    int  exp_n = 0, exp_base = 0, got_w = 0, start_cyc = 0, last_we_cyc = 0;
    int  exp_first_cyc = 0, launches = 0, rises = 0;
    int  run_q[$];
    bit  prev_sck = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(spi_cs_n == 1'b0, "R2", "cs_n", spi_cs_n, 0);
            if (!busy) chk(spi_sck == 1'b0, "R3", "sck idle", spi_sck, 0);
            if (prev_sck) chk(spi_sck == 1'b0, "R3", "sck high twice", spi_sck, 0);
            if (mem_we) begin
                if (got_w == 0)
                    chk(cyc == exp_first_cyc, "R10", "first write cycle", cyc, exp_first_cyc);
                chk(int'(mem_addr) == (exp_base + got_w) % (1 << ADDR_W), "R6", "addr",
                    int'(mem_addr), (exp_base + got_w) % (1 << ADDR_W));
                chk(mem_wdata == fbyte(got_w), "R5", "data", mem_wdata, fbyte(got_w));
                got_w++;
                last_we_cyc = cyc;
            end
            if (launch) begin
                launches++;
                if (exp_n == 0)
                    chk(cyc == start_cyc, "R7", "zero-count launch cycle", cyc, start_cyc);
                else
                    chk(cyc == last_we_cyc + 2, "R8", "launch cycle", cyc, last_we_cyc + 2);
            end
            if (spi_sck && !prev_sck) rises++;
            else if (!spi_sck && !prev_sck && rises > 0) begin
                chk(run_q.size() > 0 && rises == run_q[0], "R4", "run edges", rises,
                    run_q.size() > 0 ? run_q[0] : -1);
                if (run_q.size() > 0) void'(run_q.pop_front());
                rises = 0;
            end
            if (prev_sck && !spi_sck) fptr++;
            prev_sck = spi_sck;
        end
    end

    task automatic wait_launch();
        int k = 0;
        while (launches == 0 && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(launches == 1, "R8", "launch count", launches, 1);
    endtask

    task automatic run_xfer(int n, int base, int poke);
        int rem = n;
        @(negedge clk);
        exp_n = n; exp_base = base; got_w = 0; fptr = 0; launches = 0; rises = 0;
        run_q.delete();
        while (rem > 0) begin
            int c = (rem > CHUNK_MAX) ? CHUNK_MAX : rem;
            run_q.push_back(c * 8);
            rem -= c;
        end
        byte_count = CNT_W'(n); base_addr = ADDR_W'(base); start = 1'b1;
        start_cyc = cyc + 1;
        exp_first_cyc = start_cyc + 17 + LAT;
        @(negedge clk);
        start = 1'b0;
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            // R9: a second request while streaming must be ignored
            byte_count = CNT_W'(2); base_addr = ADDR_W'(5); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_launch();
        chk(got_w == n, "R6", "write count", got_w, n);
        chk(run_q.size() == 0, "R4", "runs left", run_q.size(), 0);
        @(negedge clk);
        chk(done == 1'b1, "R8", "done after launch", done, 1);
        chk(busy == 1'b0, "R9", "idle after launch", busy, 0);
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R8", "done held", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(spi_sck == 0 && mem_we == 0 && busy == 0 && done == 0 && launch == 0,
            "R1", "outputs in reset", {spi_sck, mem_we, busy, done, launch}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_sck == 0 && mem_we == 0 && busy == 0 && done == 0 && launch == 0,
            "R1", "outputs after reset", {spi_sck, mem_we, busy, done, launch}, 0);

        run_xfer(3, 16, 0);      // R5 R6 R10 single short chunk
        run_xfer(4, 100, 0);     // R4 exactly one full chunk
        run_xfer(11, 200, 0);    // R4 chunks 4,4,3
        run_xfer(1, 7, 0);       // R10 single byte
        run_xfer(9, 1022, 30);   // R6 address wrap, R9 start while streaming

        // R7 + R9: zero count, then start held in the launch cycle
        @(negedge clk);
        exp_n = 0; got_w = 0; fptr = 0; launches = 0; rises = 0; run_q.delete();
        byte_count = '0; start = 1'b1; start_cyc = cyc + 1;
        @(negedge clk);
        chk(launch == 1'b1, "R7", "launch right after start", launch, 1);
        byte_count = CNT_W'(3);  // still requesting during the launch cycle
        @(negedge clk);
        start = 1'b0;
        repeat (80) @(negedge clk);
        chk(launches == 1, "R9", "launches after collision", launches, 1);
        chk(got_w == 0, "R7", "writes for zero count", got_w, 0);
        chk(fptr == 0, "R7", "clock falls for zero count", fptr, 0);
        chk(done == 1'b1 && busy == 1'b0, "R9", "done/busy after collision",
            {done, busy}, 2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule